// File: doc/BRIEF.md
# Streaming Lempel-Ziv Byte Compressor

This block turns a stream of plain bytes into a packed stream of compression tokens. It keeps the most recent 512 input bytes in a history store. Every incoming byte is compared against every stored byte in the same cycle. While the new bytes keep extending a string that already appears in the history, the block builds a copy reference. When no stored string continues, it sends the pending data out as either a single literal byte or a copy token. Tokens are packed bit by bit, most significant bit first, into bytes that leave on a valid/ready port.

A one-cycle `start` pulse opens a frame and wipes the history, so no frame can refer back to an earlier one. The input byte that carries `in_last` closes the frame. After it, the block sends any pending token, then an end code, then zero bits up to the next byte boundary. When the output side stalls, input acceptance stops until the packer has room again. No bits are lost.

Top module: `lz_compressor`

## Requirements
- R1: A byte that does not continue a stored string of at least two bytes is sent as a 9-bit literal: a 0 bit followed by the byte, most significant bit first.
- R2: The `start` pulse empties the history. Stored positions that have not been written since then never match, even when the incoming byte equals their old or reset contents. A second frame's output does not depend on the first frame.
- R3: A matched string of length L (2..16) is sent as a 14-bit copy token: a 1 bit, a 4-bit code equal to L-2, and the 9-bit history position of the string's first byte. Positions count from 0, in the order the bytes were written after `start`.
- R4: After the tokens for the last input byte, the block appends the 5-bit end code `11111` and then zero bits up to the next byte boundary. No further bytes follow.
- R5: Token bits are packed most significant bit first. The first bit of the frame is bit 7 of the first output byte.
- R6: A match is closed and sent as soon as it reaches 16 bytes. The next byte then begins a new token.
- R7: The history write position wraps modulo 512. A frame longer than 512 bytes still decodes exactly against a 512-byte ring.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value. Output stalls throttle `in_ready` and never drop or reorder bits.
- R9: `in_ready` is low out of reset and after the last byte of a frame has been accepted, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: clear history, open a frame |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | 8 | Plain input byte |
| in_last | input | 1 | Marks the final byte of the frame |
| out_valid | output | 1 | Packed output byte present |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Packed compressed byte |

## Verification
A token appears in the bit accumulator at the clock edge that accepts its byte. The byte that holds its first bit is loaded into the registered output one edge later at the earliest, so the exact results are only known once the frame has drained. For that reason the bench records each output byte at the moment of its handshake: it sets `out_ready` just after the falling edge and then samples `out_valid`, `out_data` and `in_ready`, which stay stable until the next rising edge. A frame counts as finished after 30 quiet cycles. Only then are the gathered bytes compared with hand-derived streams or decoded with an independent model. The stall rule is checked one cycle after each stalled handshake.

// File: rtl/lz_pkg.sv
package lz_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH,
    ST_ENDM,
    ST_PAD
  } lz_state_t;
endpackage

// File: rtl/lz_hist_cam.sv
module lz_hist_cam #(
  parameter int DEPTH = 512,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             restart,
  input  logic             extend,
  output logic             any_cont,
  output logic [PTR_W-1:0] cont_end,
  output logic [PTR_W-1:0] act_end
);
  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] filled;
  logic [DEPTH-1:0] act;
  logic [DEPTH-1:0] eq;
  logic [DEPTH-1:0] cont;
  logic [PTR_W-1:0] wp;

  // one compare cell per stored byte; the slot about to be overwritten is excluded
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam int PREV = (g == 0) ? DEPTH - 1 : g - 1;
    assign eq[g]   = filled[g] && (mem[g] == wr_data) && (PTR_W'(g) != wp);
    assign cont[g] = eq[g] && act[PREV];
  end

  function automatic logic [PTR_W-1:0] lowest_set(input logic [DEPTH-1:0] v);
    lowest_set = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (v[i]) lowest_set = PTR_W'(i);
  endfunction

  assign any_cont = |cont;
  assign cont_end = lowest_set(cont);
  assign act_end  = lowest_set(act);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      filled <= '0;
      act    <= '0;
      wp     <= '0;
    end else if (wr_en) begin
      filled[wp] <= 1'b1;
      wp         <= wp + 1'b1;
      if (extend)       act <= cont;
      else if (restart) act <= eq;
      else              act <= '0;
    end
  end

  AST_CLEAR_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    clear |=> (eq == '0)); // R2
endmodule

// File: rtl/lz_bit_packer.sv
module lz_bit_packer #(
  parameter int ACC_W = 32,
  parameter int TOK_W = 14,
  parameter int TL_W  = $clog2(TOK_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_valid,
  input  logic [TOK_W-1:0] tok_bits,
  input  logic [TL_W-1:0]  tok_len,
  input  logic             pad_req,
  output logic             tok_ready,
  output logic             empty,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_data
);
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc, acc_d, acc_n;
  logic [CNT_W-1:0] cnt, cnt_d, cnt_n;
  logic             drain;

  assign tok_ready = (cnt <= CNT_W'(ACC_W - TOK_W));
  assign empty     = (cnt == '0);
  assign drain     = (cnt >= CNT_W'(8)) && (!out_valid || out_ready);

  always_comb begin
    acc_d = drain ? (acc << 8) : acc;
    cnt_d = drain ? (cnt - CNT_W'(8)) : cnt;
    acc_n = acc_d;
    cnt_n = cnt_d;
    if (tok_valid) begin
      acc_n = acc_d | ({tok_bits, {(ACC_W - TOK_W){1'b0}}} >> cnt_d);
      cnt_n = cnt_d + CNT_W'(tok_len);
    end else if (pad_req && (cnt_d != '0) && (cnt_d < CNT_W'(8))) begin
      cnt_n = CNT_W'(8);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      acc <= acc_n;
      cnt <= cnt_n;
      if (drain) begin
        out_valid <= 1'b1;
        out_data  <= acc[ACC_W-1 -: 8];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    tok_valid |-> tok_ready); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(ACC_W)); // R5
endmodule

// File: rtl/lz_compressor.sv
module lz_compressor
  import lz_pkg::*;
#(
  parameter int HIST_DEPTH = 512,
  parameter int LEN_W      = 4,
  parameter int ACC_W      = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int PTR_W   = $clog2(HIST_DEPTH);
  localparam int MAX_LEN = 2 ** LEN_W;
  localparam int LCNT_W  = LEN_W + 1;
  localparam int TOK_W   = 1 + LEN_W + PTR_W;
  localparam int TL_W    = $clog2(TOK_W + 1);
  localparam logic [TL_W-1:0] LIT_LEN  = TL_W'(1 + BYTE_W);
  localparam logic [TL_W-1:0] COPY_LEN = TL_W'(TOK_W);
  localparam logic [TL_W-1:0] END_LEN  = TL_W'(1 + LEN_W);
  localparam logic [TOK_W-1:0] END_TOK = {1'b1, {LEN_W{1'b1}}, {PTR_W{1'b0}}};

  lz_state_t         state, state_n;
  logic [LCNT_W-1:0] cur_len, len_n;
  logic [7:0]        lit_byte, lit_n;
  logic              accept, tok_valid, tok_ready, pk_empty, pad_req;
  logic [TOK_W-1:0]  tok_bits, pend_bits;
  logic [TL_W-1:0]   tok_len, pend_len;
  logic              cam_wr, cam_restart, cam_extend, clear;
  logic              any_cont;
  logic [PTR_W-1:0]  cont_end, act_end;

  function automatic logic [TOK_W-1:0] copy_tok(input logic [LCNT_W-1:0] len,
                                                input logic [PTR_W-1:0] last_pos);
    logic [PTR_W-1:0] first_pos;
    first_pos = last_pos - PTR_W'(len - 1'b1);
    return {1'b1, LEN_W'(len - LCNT_W'(2)), first_pos};
  endfunction

  lz_hist_cam #(.DEPTH(HIST_DEPTH), .PTR_W(PTR_W)) i_cam (
    .clk(clk), .rst(rst), .clear(clear), .wr_en(cam_wr), .wr_data(in_data),
    .restart(cam_restart), .extend(cam_extend), .any_cont(any_cont),
    .cont_end(cont_end), .act_end(act_end)
  );

  lz_bit_packer #(.ACC_W(ACC_W), .TOK_W(TOK_W), .TL_W(TL_W)) i_pack (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_bits(tok_bits),
    .tok_len(tok_len), .pad_req(pad_req), .tok_ready(tok_ready), .empty(pk_empty),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  assign in_ready  = (state == ST_RUN) && tok_ready && !start;
  assign accept    = in_valid && in_ready;
  assign pend_bits = (cur_len == LCNT_W'(1))
                   ? {1'b0, lit_byte, {(TOK_W - 1 - BYTE_W){1'b0}}}
                   : copy_tok(cur_len, act_end);
  assign pend_len  = (cur_len == LCNT_W'(1)) ? LIT_LEN : COPY_LEN;

  always_comb begin
    state_n     = state;
    len_n       = cur_len;
    lit_n       = lit_byte;
    tok_valid   = 1'b0;
    tok_bits    = pend_bits;
    tok_len     = pend_len;
    cam_wr      = 1'b0;
    cam_restart = 1'b0;
    cam_extend  = 1'b0;
    clear       = 1'b0;
    pad_req     = 1'b0;
    if (start) begin
      clear   = 1'b1;
      state_n = ST_RUN;
      len_n   = '0;
    end else begin
      unique case (state)
        ST_RUN: if (accept) begin
          cam_wr = 1'b1;
          if ((cur_len != '0) && any_cont) begin
            cam_extend = 1'b1;
            if (cur_len == LCNT_W'(MAX_LEN - 1)) begin
              tok_valid = 1'b1;
              tok_bits  = copy_tok(LCNT_W'(MAX_LEN), cont_end);
              tok_len   = COPY_LEN;
              len_n     = '0;
            end else begin
              len_n = cur_len + 1'b1;
            end
          end else begin
            tok_valid   = (cur_len != '0);
            cam_restart = 1'b1;
            len_n       = LCNT_W'(1);
            lit_n       = in_data;
          end
          if (in_last) state_n = ST_FLUSH;
        end
        ST_FLUSH: if (tok_ready) begin
          tok_valid = (cur_len != '0);
          len_n     = '0;
          state_n   = ST_ENDM;
        end
        ST_ENDM: if (tok_ready) begin
          tok_valid = 1'b1;
          tok_bits  = END_TOK;
          tok_len   = END_LEN;
          state_n   = ST_PAD;
        end
        ST_PAD: begin
          pad_req = 1'b1;
          if (pk_empty) state_n = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_len  <= '0;
      lit_byte <= '0;
    end else begin
      state    <= state_n;
      cur_len  <= len_n;
      lit_byte <= lit_n;
    end
  end

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
    cur_len < LCNT_W'(MAX_LEN)); // R6
  AST_PAD_NO_TOKEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAD) |-> !tok_valid); // R4
  AST_CLOSED_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (accept && in_last && !start) |=> !in_ready); // R9
endmodule

// File: tb/test_lz_compressor.sv
module test_lz_compressor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;

  int checks = 0;
  int failures = 0;
  int out_n = 0;
  int stall_bad = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;
  bit prev_stall = 1'b0;
  logic [7:0]  prev_data = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  in_buf  [0:1023];
  logic [7:0]  out_buf [0:2047];
  logic [7:0]  exp_buf [0:15];
  logic [7:0]  ring    [0:511];

  always #4 clk = ~clk;

  lz_compressor i_lz_compressor (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // output side: set ready after the falling edge, then record the handshake
  always @(negedge clk) begin
    if (bp_mode) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[5];
    end else begin
      out_ready = 1'b1;
    end
    #1;
    if (prev_stall && (!out_valid || out_data != prev_data)) stall_bad++;
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (out_valid && out_ready) begin
      out_buf[out_n] = out_data;
      out_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit last);
    in_valid = 1'b1;
    in_data  = b;
    in_last  = last;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_frame(input int n, input bit bp);
    int idle;
    bp_mode = bp;
    @(negedge clk);
    out_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) push(in_buf[i], i == n - 1);
    idle = 0;
    while (idle < 30) begin
      @(negedge clk);
      #2;
      if (out_valid) idle = 0;
      else idle++;
    end
  endtask

  task automatic check_stream(input string req, input int en);
    check(out_n == en, {req, " byte count"}, out_n, en);
    for (int i = 0; i < en && i < out_n; i++)
      check(out_buf[i] == exp_buf[i], req, out_buf[i], exp_buf[i]);
  endtask

  function automatic int get_bits(input int pos, input int w);
    int v = 0;
    for (int k = 0; k < w; k++)
      v = (v << 1) | int'(out_buf[(pos + k) / 8][7 - ((pos + k) % 8)]);
    return v;
  endfunction

  // independent decoder against a 512-byte ring (R3, R4, R7)
  task automatic decode_and_check(input int n);
    int pos = 0;
    int dn = 0;
    int bad = 0;
    int code, len, src;
    bit ended = 1'b0;
    while (!ended && pos < out_n * 8) begin
      if (get_bits(pos, 1) == 0) begin
        ring[dn % 512] = 8'(get_bits(pos + 1, 8));
        if (dn >= n || ring[dn % 512] != in_buf[dn]) bad++;
        dn++;
        pos += 9;
      end else begin
        code = get_bits(pos + 1, 4);
        if (code == 15) begin
          ended = 1'b1;
          pos += 5;
        end else begin
          len = code + 2;
          src = get_bits(pos + 5, 9);
          for (int k = 0; k < len; k++) begin
            ring[dn % 512] = ring[(src + k) % 512];
            if (dn >= n || ring[dn % 512] != in_buf[dn]) bad++;
            dn++;
          end
          pos += 14;
        end
      end
    end
    check(ended, "R4 end code found", ended, 1);
    check(dn == n, "R7 decoded length", dn, n);
    check(bad == 0, "R7 decoded bytes match", bad, 0);
    check(((pos + 7) / 8) == out_n, "R4 no bytes after padding", out_n, (pos + 7) / 8);
    if (ended && (pos % 8) != 0)
      check(get_bits(pos, 8 - (pos % 8)) == 0, "R4 pad bits zero", get_bits(pos, 8 - (pos % 8)), 0);
  endtask

  task automatic t_reset;
    #1;
    check(out_valid == 1'b0, "R8 out_valid after reset", out_valid, 0);
    in_valid = 1'b1;
    #1;
    check(in_ready == 1'b0, "R9 in_ready low after reset", in_ready, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_single;
    in_buf[0] = 8'h41;
    run_frame(1, 1'b0);
    exp_buf[0] = 8'h20; exp_buf[1] = 8'hFC;
    check_stream("R1 R5 literal then end code", 2);
    in_valid = 1'b1;
    #1;
    check(in_ready == 1'b0, "R9 in_ready low after frame", in_ready, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_repeat;
    for (int i = 0; i < 4; i++) in_buf[i] = 8'h41;
    run_frame(4, 1'b0);
    exp_buf[0] = 8'h20; exp_buf[1] = 8'hC4; exp_buf[2] = 8'h01; exp_buf[3] = 8'hF0;
    check_stream("R3 copy token length 3 from position 0", 4);
  endtask

  task automatic t_cap;
    for (int i = 0; i < 18; i++) in_buf[i] = 8'h00;
    run_frame(18, 1'b0);
    exp_buf[0] = 8'h00; exp_buf[1] = 8'h78; exp_buf[2] = 8'h00;
    exp_buf[3] = 8'h00; exp_buf[4] = 8'hF8;
    check_stream("R6 R2 cap at 16 and zero bytes vs empty history", 5);
  endtask

  task automatic t_restart;
    for (int i = 0; i < 4; i++) in_buf[i] = 8'h41;
    run_frame(4, 1'b0);
    exp_buf[0] = 8'h20; exp_buf[1] = 8'hC4; exp_buf[2] = 8'h01; exp_buf[3] = 8'hF0;
    check_stream("R2 second frame independent of first", 4);
  endtask

  task automatic t_long_stall;
    for (int i = 0; i < 700; i++)
      in_buf[i] = ((i % 37) < 20) ? 8'(i % 37) : 8'((i * 13) & 255);
    stall_bad = 0;
    run_frame(700, 1'b1);
    decode_and_check(700);
    check(stall_bad == 0, "R8 output held during stall", stall_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_repeat();
    t_cap();
    t_restart();
    t_long_stall();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule